// File: doc/BRIEF.md
# MDIO Management Controller

This block lets software on the register side reach PHY registers over a two-wire management bus using clause-22 frames. A single command word at offset 0x00 holds the PHY address, the register number, the operation and, for writes, the 16-bit value to send. Writing that word while the unit is idle launches a frame at once. The busy flag in the same word stays set until the last bit has been clocked. After a read, the captured 16-bit value and a read-valid flag appear in the same word.

Each completed frame sets a done cause bit at offset 0x7C. A mask register at offset 0x80 gates that bit onto the interrupt output. Software clears the cause by writing 0 to its bit position. The management clock comes from a divider of the system clock that is sized at elaboration so it never runs faster than a given maximum.

The frame engine is a state machine with these states. IDLE waits for a start. PREAMBLE sends 32 ones. HEADER sends the start pattern, the opcode, the PHY address and the register number. TURN covers the two turnaround bits. DATA covers the 16 data bits. The transitions are as follows. IDLE goes to PREAMBLE on an accepted command write. PREAMBLE goes to HEADER after bit 31. HEADER goes to TURN after bit 45. TURN goes to DATA after bit 47. DATA goes back to IDLE after bit 63. Every transition, apart from the one out of IDLE, happens on an MDC falling edge.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: The word at 0x00 reads back with the data field in bits 15:0, the PHY address in 20:16, the register number in 25:21, the operation in bit 26 (1 = read, 0 = write), read-valid in bit 27, busy in bit 28, and zeros in bits 31:29.
- R2: A write to 0x00 while busy is 0 starts a frame. Busy reads 1 from the next cycle and stays 1 for exactly 128 × DIV_HALF system cycles, where DIV_HALF = ceil(CLK_HZ / (2 × MDC_MAX_HZ)).
- R3: A frame is 64 bits, sent MSB first, in this order: 32 ones, start 01, opcode 10 (read) or 01 (write), the 5-bit PHY address, the 5-bit register number, turnaround 10 on a write, and 16 data bits. MDIO output changes only in the cycle after MDC falls.
- R4: On a read, the output enable is low from the first turnaround bit (bit 46) to the end of the frame, and MDIO is sampled when MDC rises. At completion, bits 15:0 hold the sampled value, MSB first, and read-valid is 1.
- R5: A completed write frame leaves read-valid at 0. Any accepted command clears read-valid in the cycle after it is written.
- R6: A write to 0x00 while busy is 1 is ignored. The frame on the wire and the fields of the command word are unchanged.
- R7: While busy, MDC is high for DIV_HALF cycles and low for DIV_HALF cycles. While idle, MDC is low.
- R8: Bit 4 of 0x7C is set by every completed frame. A write to 0x7C with bit 4 = 0 clears it, and a write with bit 4 = 1 leaves it as it was. All other bits read 0.
- R9: Bit 4 of 0x80 is the interrupt enable, and its other bits read 0. The interrupt output equals cause bit AND enable bit.
- R10: After reset, all three registers read 0, the interrupt is low, MDC is low and MDIO is released (output enable 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_i | input | 1 | Register write strobe, one cycle per write |
| reg_addr_i | input | 8 | Byte offset of the register accessed |
| reg_wdata_i | input | 27 | Write data: command bits 26:0, or bit 4 for cause and mask |
| reg_rdata_o | output | 32 | Combinational read data for reg_addr_i |
| irq_o | output | 1 | Interrupt request, cause AND mask |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Management data driven toward the PHY |
| mdio_oe_o | output | 1 | High while the controller drives MDIO |
| mdio_i | input | 1 | Management data from the pad |

## Verification
The bench runs random read and write commands with random PHY addresses, register numbers and data. A PHY model captures all 64 bits and the output enable at each MDC rise, so a wrong field order, a wrong opcode or turnaround, or an early release of the line shows up as a bit mismatch. Read replies are derived from the address pair, so a shifted or reversed capture gives a different value from the one expected. Directed cases cover the following: a command write during a frame, which tells "ignored" apart from "restarted" or "fields overwritten"; a write right after a read, which shows whether read-valid is cleared; and writes to the cause and mask registers with the enable bit at 1 and at 0, which tell clear-on-zero apart from clear-on-one and show whether the interrupt is gated.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREAMBLE,
        ST_HEADER,
        ST_TURN,
        ST_DATA
    } frame_state_e;

    // Layout of the writable part of the command word (bits 26:0)
    typedef struct packed {
        logic       rd;
        logic [4:0] reg_num;
        logic [4:0] phy;
        logic [15:0] data;
    } mdio_cmd_t;

    localparam int FRAME_BITS = 64;
    localparam int PRE_BITS   = 32;
    localparam int TURN_FIRST = 46;
    localparam int DATA_FIRST = 48;
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);

    localparam int ADDR_W     = 8;
    localparam int WR_W       = $bits(mdio_cmd_t);
    localparam int RD_W       = 32;
    localparam int EVT_BIT    = 4;

    localparam logic [ADDR_W-1:0] OFF_CMD   = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_CAUSE = 8'h7C;
    localparam logic [ADDR_W-1:0] OFF_MASK  = 8'h80;

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
    parameter int DIV_HALF = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic mdc_o,
    output logic rise_o,
    output logic fall_o
);
    localparam int DW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
    localparam logic [DW-1:0] LAST = DW'(DIV_HALF - 1);

    logic [DW-1:0] cnt_q;
    logic          mdc_q;
    logic          wrap;

    assign wrap   = run_i && (cnt_q == LAST);
    assign rise_o = wrap && !mdc_q;
    assign fall_o = wrap && mdc_q;
    assign mdc_o  = mdc_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (wrap) begin
            cnt_q <= '0;
            mdc_q <= ~mdc_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_mgmt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  mdio_cmd_t   cmd_i,
    input  logic        mdc_i,
    input  logic        rise_i,
    input  logic        fall_i,
    input  logic        mdio_i,
    output logic        mdio_o,
    output logic        mdio_oe_o,
    output logic        busy_o,
    output logic        done_o,
    output logic        done_rd_o,
    output logic [15:0] rd_data_o
);
    localparam logic [CNT_W-1:0] PRE_LAST  = CNT_W'(PRE_BITS - 1);
    localparam logic [CNT_W-1:0] HDR_LAST  = CNT_W'(TURN_FIRST - 1);
    localparam logic [CNT_W-1:0] TURN_LAST = CNT_W'(DATA_FIRST - 1);
    localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(FRAME_BITS - 1);

    frame_state_e            state_q, state_d;
    logic [CNT_W-1:0]        bit_q;
    logic [FRAME_BITS-1:0]   frame_q;
    logic                    rd_q;
    logic [15:0]             rsh_q;
    logic [FRAME_BITS-1:0]   frame_new;

    assign frame_new = {{PRE_BITS{1'b1}}, 2'b01,
                        cmd_i.rd ? 2'b10 : 2'b01,
                        cmd_i.phy, cmd_i.reg_num,
                        2'b10, cmd_i.data};

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (start_i)                        state_d = ST_PREAMBLE;
            ST_PREAMBLE: if (fall_i && bit_q == PRE_LAST)    state_d = ST_HEADER;
            ST_HEADER:   if (fall_i && bit_q == HDR_LAST)    state_d = ST_TURN;
            ST_TURN:     if (fall_i && bit_q == TURN_LAST)   state_d = ST_DATA;
            ST_DATA:     if (fall_i && bit_q == DATA_LAST)   state_d = ST_IDLE;
            default:                                         state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // shift path
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_q   <= '0;
            frame_q <= '1;
            rd_q    <= 1'b0;
            rsh_q   <= '0;
        end else if (state_q == ST_IDLE) begin
            if (start_i) begin
                bit_q   <= '0;
                frame_q <= frame_new;
                rd_q    <= cmd_i.rd;
            end
        end else begin
            if (fall_i) begin
                bit_q   <= bit_q + 1'b1;
                frame_q <= {frame_q[FRAME_BITS-2:0], 1'b1};
            end
            if (rise_i && rd_q && state_q == ST_DATA)
                rsh_q <= {rsh_q[14:0], mdio_i};
        end
    end

    // outputs
    always_comb begin
        busy_o    = (state_q != ST_IDLE);
        mdio_o    = busy_o ? frame_q[FRAME_BITS-1] : 1'b1;
        mdio_oe_o = busy_o && !(rd_q && (state_q == ST_TURN || state_q == ST_DATA));
        done_o    = (state_q == ST_DATA) && fall_i && (bit_q == DATA_LAST);
        done_rd_o = done_o && rd_q;
        rd_data_o = rsh_q;
    end

    // R2
    start_to_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> busy_o);

    // R3
    mdio_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o) && !$stable(mdio_o)) |-> $fell(mdc_i));

endmodule

// File: rtl/mdio_reg_file.sv
module mdio_reg_file
    import mdio_mgmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [WR_W-1:0]   wdata_i,
    output logic [RD_W-1:0]   rdata_o,
    input  logic              busy_i,
    input  logic              done_i,
    input  logic              done_rd_i,
    input  logic [15:0]       rd_data_i,
    output logic              start_o,
    output mdio_cmd_t         cmd_o,
    output logic              irq_o
);
    mdio_cmd_t cmd_q;
    logic      rd_valid_q;
    logic      cause_q;
    logic      mask_q;
    logic      wr_cmd, wr_cause, wr_mask;

    assign wr_cmd   = wr_i && (addr_i == OFF_CMD);
    assign wr_cause = wr_i && (addr_i == OFF_CAUSE);
    assign wr_mask  = wr_i && (addr_i == OFF_MASK);
    assign start_o  = wr_cmd && !busy_i;
    assign cmd_o    = mdio_cmd_t'(wdata_i);
    assign irq_o    = cause_q && mask_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q      <= '0;
            rd_valid_q <= 1'b0;
        end else if (start_o) begin
            cmd_q      <= cmd_o;
            rd_valid_q <= 1'b0;
        end else if (done_rd_i) begin
            cmd_q.data <= rd_data_i;
            rd_valid_q <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause_q <= 1'b0;
            mask_q  <= 1'b0;
        end else begin
            if (done_i)
                cause_q <= 1'b1;
            else if (wr_cause)
                cause_q <= cause_q && wdata_i[EVT_BIT];
            if (wr_mask)
                mask_q <= wdata_i[EVT_BIT];
        end
    end

    always_comb begin
        unique case (addr_i)
            OFF_CMD:   rdata_o = {3'b000, busy_i, rd_valid_q, cmd_q};
            OFF_CAUSE: rdata_o = RD_W'(cause_q) << EVT_BIT;
            OFF_MASK:  rdata_o = RD_W'(mask_q) << EVT_BIT;
            default:   rdata_o = '0;
        endcase
    end

    // R4
    read_valid_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_rd_i |=> (rd_valid_q && cmd_q.data == $past(rd_data_i)));

    // R5
    start_clears_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !rd_valid_q);

    // R6
    busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmd && busy_i && !done_i) |=> $stable(cmd_q));

    // R8
    cause_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |=> cause_q);

endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
    import mdio_mgmt_pkg::*;
#(
    parameter int CLK_HZ     = 100_000_000,
    parameter int MDC_MAX_HZ = 2_500_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [WR_W-1:0]   reg_wdata_i,
    output logic [RD_W-1:0]   reg_rdata_o,
    output logic              irq_o,
    output logic              mdc_o,
    output logic              mdio_o,
    output logic              mdio_oe_o,
    input  logic              mdio_i
);
    localparam int DIV_RAW  = (CLK_HZ + 2 * MDC_MAX_HZ - 1) / (2 * MDC_MAX_HZ);
    localparam int DIV_HALF = (DIV_RAW < 1) ? 1 : DIV_RAW;

    logic        busy, done, done_rd, start, rise, fall;
    logic [15:0] rd_data;
    mdio_cmd_t   cmd;

    mdio_reg_file u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (reg_wr_i),
        .addr_i    (reg_addr_i),
        .wdata_i   (reg_wdata_i),
        .rdata_o   (reg_rdata_o),
        .busy_i    (busy),
        .done_i    (done),
        .done_rd_i (done_rd),
        .rd_data_i (rd_data),
        .start_o   (start),
        .cmd_o     (cmd),
        .irq_o     (irq_o)
    );

    mdio_mdc_gen #(.DIV_HALF(DIV_HALF)) u_mdc (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (busy),
        .mdc_o  (mdc_o),
        .rise_o (rise),
        .fall_o (fall)
    );

    mdio_frame_engine u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start),
        .cmd_i     (cmd),
        .mdc_i     (mdc_o),
        .rise_i    (rise),
        .fall_i    (fall),
        .mdio_i    (mdio_i),
        .mdio_o    (mdio_o),
        .mdio_oe_o (mdio_oe_o),
        .busy_o    (busy),
        .done_o    (done),
        .done_rd_o (done_rd),
        .rd_data_o (rd_data)
    );

endmodule

// File: tb/mdio_mgmt_ctrl_tb.sv
module mdio_mgmt_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CLK_HZ     = 10_000_000;
    localparam int MDC_HZ     = 2_500_000;
    localparam int DIV_HALF   = 2;
    localparam int FRAME_CYC  = 128 * DIV_HALF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic [26:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq, mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int n_cmp = 0;
    int n_bad = 0;

    mdio_mgmt_ctrl #(.CLK_HZ(CLK_HZ), .MDC_MAX_HZ(MDC_HZ)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr_i(wr), .reg_addr_i(addr),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq),
        .mdc_o(mdc), .mdio_o(mdio_o), .mdio_oe_o(mdio_oe), .mdio_i(mdio_i));

    always #(CLK_PERIOD/2) clk = ~clk;

    // PHY model: capture at MDC rise, answer on MDC fall
    int          rise_idx = 0;
    logic [63:0] cap_bits = '0;
    logic [63:0] cap_oe = '0;
    logic [15:0] phy_reply = '0;
    time         t_rise = 0;
    time         t_hi_min = 64'hFFFF_FFFF;
    time         t_hi_max = 0;
    time         t_per_min = 64'hFFFF_FFFF;
    time         t_per_max = 0;

    always @(posedge mdc) begin
        if (rise_idx < 64) begin
            cap_bits[63-rise_idx] = mdio_o;
            cap_oe[63-rise_idx]   = mdio_oe;
        end
        if (rise_idx > 0) begin
            if ($time - t_rise < t_per_min) t_per_min = $time - t_rise;
            if ($time - t_rise > t_per_max) t_per_max = $time - t_rise;
        end
        t_rise = $time;
        rise_idx++;
    end

    always @(negedge mdc) begin
        if ($time - t_rise < t_hi_min) t_hi_min = $time - t_rise;
        if ($time - t_rise > t_hi_max) t_hi_max = $time - t_rise;
        if (rise_idx >= 48 && rise_idx <= 63) mdio_i = phy_reply[63-rise_idx];
        else                                  mdio_i = 1'b1;
    end

    function automatic logic [15:0] model_reply(input logic [4:0] phy, input logic [4:0] rg);
        return {rg, phy, 6'b101101} ^ 16'h3C5A;
    endfunction

    function automatic logic [63:0] exp_frame(input logic rd, input logic [4:0] phy,
                                              input logic [4:0] rg, input logic [15:0] d);
        return {32'hFFFF_FFFF, 2'b01, rd ? 2'b10 : 2'b01, phy, rg, 2'b10, d};
    endfunction

    function automatic logic [63:0] exp_oe(input logic rd);
        return rd ? {{46{1'b1}}, {18{1'b0}}} : {64{1'b1}};
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [26:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic wait_idle(output int cycles);
        logic [31:0] v;
        cycles = 0;
        reg_read(8'h00, v);
        while (v[28] && cycles < 10000) begin
            cycles++;
            @(negedge clk);
            reg_read(8'h00, v);
        end
    endtask

    task automatic run_cmd(input logic rd, input logic [4:0] phy,
                           input logic [4:0] rg, input logic [15:0] d);
        int          cyc;
        logic [31:0] v;
        logic [15:0] rep;
        rep       = model_reply(phy, rg);
        phy_reply = rep;
        rise_idx  = 0;
        reg_write(8'h00, {rd, rg, phy, d});
        wait_idle(cyc);
        // R2 busy length
        chk("R2", "busy cycles", 64'(cyc), 64'(FRAME_CYC));
        if (rd) begin
            // R3 header bits of a read
            chk("R3", "read header", {18'b0, cap_bits[63:18]},
                {18'b0, exp_frame(1'b1, phy, rg, 16'h0)} >> 18);
        end else begin
            // R3 whole write frame
            chk("R3", "write frame", cap_bits, exp_frame(1'b0, phy, rg, d));
        end
        // R4 release pattern
        chk("R4", "oe pattern", cap_oe, exp_oe(rd));
        reg_read(8'h00, v);
        // R1 / R4 / R5 command word after completion
        if (rd)
            chk("R4", "read result word", 64'(v), 64'({3'b000, 1'b0, 1'b1, 1'b1, rg, phy, rep}));
        else
            chk("R5", "write result word", 64'(v), 64'({3'b000, 1'b0, 1'b0, 1'b0, rg, phy, d}));
        reg_read(8'h7C, v);
        // R8 cause set by completion
        chk("R8", "cause after frame", 64'(v), 64'h10);
        // R7 idle clock low
        chk("R7", "mdc idle", 64'(mdc), 64'h0);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : stim
        logic [31:0] v;
        int          cyc;
        logic [4:0]  pa, ra, pb, rb;
        logic [15:0] da;
        void'($urandom(32'd20240611));

        repeat (4) @(negedge clk);
        // R10 values during reset
        chk("R10", "mdc in reset", 64'(mdc), 64'h0);
        chk("R10", "oe in reset", 64'(mdio_oe), 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        reg_read(8'h00, v); chk("R10", "cmd word", 64'(v), 64'h0);
        reg_read(8'h7C, v); chk("R10", "cause", 64'(v), 64'h0);
        reg_read(8'h80, v); chk("R10", "mask", 64'(v), 64'h0);
        chk("R10", "irq", 64'(irq), 64'h0);

        // directed corners: all-ones and all-zeros fields
        run_cmd(1'b0, 5'h1F, 5'h1F, 16'hFFFF);
        run_cmd(1'b0, 5'h00, 5'h00, 16'h0000);
        run_cmd(1'b1, 5'h1F, 5'h00, 16'h0000);
        run_cmd(1'b1, 5'h00, 5'h1F, 16'hFFFF);

        // random mix
        for (int i = 0; i < 12; i++) begin
            run_cmd(1'($urandom % 2), 5'($urandom), 5'($urandom), 16'($urandom));
        end

        // R7 clock shape seen over all frames
        chk("R7", "mdc high min", 64'(t_hi_min), 64'(DIV_HALF * CLK_PERIOD));
        chk("R7", "mdc high max", 64'(t_hi_max), 64'(DIV_HALF * CLK_PERIOD));
        chk("R7", "mdc period min", 64'(t_per_min), 64'(2 * DIV_HALF * CLK_PERIOD));
        chk("R7", "mdc period max", 64'(t_per_max), 64'(2 * DIV_HALF * CLK_PERIOD));

        // R6: second command while busy must be ignored
        pa = 5'h0A; ra = 5'h13; pb = 5'h15; rb = 5'h04; da = 16'hBEEF;
        phy_reply = model_reply(pa, ra);
        rise_idx  = 0;
        reg_write(8'h00, {1'b1, ra, pa, 16'h0000});
        repeat (40) @(negedge clk);
        reg_write(8'h00, {1'b0, rb, pb, da});
        reg_read(8'h00, v);
        chk("R6", "fields during busy", 64'(v[26:0]), 64'({1'b1, ra, pa, 16'h0000}));
        wait_idle(cyc);
        chk("R6", "frame header kept", {18'b0, cap_bits[63:18]},
            {18'b0, exp_frame(1'b1, pa, ra, 16'h0)} >> 18);
        chk("R6", "oe kept as read", cap_oe, exp_oe(1'b1));
        reg_read(8'h00, v);
        chk("R6", "result of first cmd", 64'(v),
            64'({3'b000, 1'b0, 1'b1, 1'b1, ra, pa, model_reply(pa, ra)}));

        // R5: a new command clears read-valid right away
        rise_idx = 0;
        reg_write(8'h00, {1'b0, 5'h02, 5'h03, 16'h1234});
        reg_read(8'h00, v);
        chk("R5", "valid cleared, busy set", 64'(v[28:27]), 64'b10);
        wait_idle(cyc);
        reg_read(8'h00, v);
        chk("R5", "valid after write", 64'(v[27]), 64'h0);

        // R8 / R9: cause and mask
        chk("R9", "irq masked", 64'(irq), 64'h0);
        reg_write(8'h80, 27'h10);
        reg_read(8'h80, v); chk("R9", "mask readback", 64'(v), 64'h10);
        chk("R9", "irq enabled", 64'(irq), 64'h1);
        reg_write(8'h80, '1);
        reg_read(8'h80, v); chk("R9", "mask other bits zero", 64'(v), 64'h10);
        reg_write(8'h7C, '1);
        reg_read(8'h7C, v); chk("R8", "write one keeps cause", 64'(v), 64'h10);
        reg_write(8'h7C, 27'h7FF_FFEF);
        reg_read(8'h7C, v); chk("R8", "write zero clears cause", 64'(v), 64'h0);
        chk("R9", "irq after clear", 64'(irq), 64'h0);
        reg_write(8'h7C, 27'h10);
        reg_read(8'h7C, v); chk("R8", "one on clear cause keeps zero", 64'(v), 64'h0);
        reg_write(8'h80, 27'h0);
        run_cmd(1'b1, 5'h07, 5'h11, 16'h0);
        chk("R9", "irq with mask off", 64'(irq), 64'h0);
        reg_write(8'h80, 27'h10);
        chk("R9", "irq once mask on", 64'(irq), 64'h1);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule